// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel flash device. After a program or erase command has been sent elsewhere, it decides whether the operation has finished. It does this by reading the device's status byte over and over at one address. A single-cycle start pulse gives it the address to poll and the expected data byte. For a program, that byte is the value written. For an erase, it is all ones. The poll address must be a valid one: the programmed location, any location in the sector being erased, or any location in an unprotected sector for a whole-chip erase.

Each poll compares the top status bit with the top bit of the expected data. If they agree, the operation is complete. If they disagree and the error flag (bit 5) is clear, the block keeps polling. If they disagree and the error flag is set, the block reads once more and compares the top bit again, because the top bit and the error flag can change together. A failure is reported only if that second read still disagrees. When the operation is judged complete, the block makes one more read, because the lower bits may become valid later than the top bit. It then presents that whole byte with the result. A host-side limit on polls ends a device that never raises its error flag with a separate timeout code.

Reads go over a plain request/acknowledge port. The request is held with a stable address until the acknowledge is seen on a clock edge, and the read data is taken on that same edge.

Top module: `flash_done_poller`

## Requirements
- R1: During and right after reset, `rd_req`, `done` and `busy` are 0, `result` is 2'b00 (none), and `data_out` is 0.
- R2: A start accepted in idle latches `addr_in`. Every read of that run shows the latched address on `rd_addr`. `rd_req` stays high, with `rd_addr` unchanged, until `rd_ack` is high on a clock edge. `rd_req` is low on the cycle after each accepted read.
- R3: When bit 7 of a poll read equals bit 7 of the latched expected data, exactly one further read follows. `done` then rises with `result` = 2'b01 (pass), and `data_out` equals the byte returned by that further read.
- R4: When bit 7 of a poll read differs from the expected bit 7 and bit 5 of that read is 0, another poll read is issued at the same address. This applies while the poll limit is not yet reached.
- R5: When bit 7 of a poll read differs and bit 5 is 1, one recheck read follows. If the recheck's bit 7 matches, the pass path of R3 follows: one more read, then pass. If it differs, `done` rises with `result` = 2'b10 (fail) and `data_out` equals the recheck byte. This holds on the last allowed poll as well.
- R6: After MAX_POLLS consecutive poll reads, each with a bit 7 mismatch and bit 5 equal to 0, `done` rises with `result` = 2'b11 (timeout) and `data_out` equals the last byte read. No further read is issued.
- R7: A start pulse while `busy` is high is ignored. The running poll keeps its address and expected data.
- R8: `done`, `result` and `data_out` hold their values until the next accepted start. On the edge that accepts a start, `done` falls, `result` returns to 2'b00, `data_out` clears, and `busy` rises.
- R9: `busy` is high from the edge that accepts a start up to the edge that raises `done`. `done` and `busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin polling |
| addr_in | input | AW | Valid address to poll, taken on start |
| expect_in | input | DW | Expected data byte (all ones for erase), taken on start |
| rd_req | output | 1 | Read request to the flash read port |
| rd_addr | output | AW | Read address, stable while rd_req is high |
| rd_ack | input | 1 | Read acknowledge; rd_data is valid when high |
| rd_data | input | DW | Byte returned by the flash |
| done | output | 1 | Polling finished; held until next start |
| result | output | 2 | 00 none, 01 pass, 10 fail, 11 timeout |
| data_out | output | DW | Full byte from the final read (or the deciding status byte) |
| busy | output | 1 | Polling in progress |

## Verification
Directed scripts of status bytes single out each branch. An immediate top-bit match separates the pass-plus-final-read path from plain polling. A top-bit mismatch with the error flag set, followed by a matching or a mismatching recheck, tells the recheck-pass outcome from a real failure. A run of mismatches with the flag clear hits the poll limit exactly. The flag set on the very last allowed poll shows that the recheck takes priority over the timeout. Erase-style expected data (all ones) and program-style values with bit 7 clear confirm that only the expected top bit steers the compare. Random byte streams with a biased top bit and error flag, plus random acknowledge latency, are compared against a reference walk of the same stream. The reference predicts the result code, the final byte and the exact number of reads. A start pulse injected mid-run shows whether a busy poller can be redirected.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    RES_NONE    = 2'b00,
    RES_PASS    = 2'b01,
    RES_FAIL    = 2'b10,
    RES_TIMEOUT = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_RECHK = 2'd2,
    ST_FINAL = 2'd3
  } st_e;
endpackage

// File: rtl/poll_rd_port.sv
module poll_rd_port #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] addr_d,
  input  logic          reading,
  input  logic          rd_ack,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          accept
);
  assign accept = rd_req && rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else begin
      if (go) begin
        rd_addr <= addr_d;
        rd_req  <= 1'b1;
      end else if (accept) begin
        rd_req <= 1'b0;
      end else if (reading) begin
        rd_req <= 1'b1;
      end
    end
  end

  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  p_req_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_ack) |=> !rd_req);
endmodule

// File: rtl/poll_watchdog.sv
module poll_watchdog #(
  parameter int MAX_POLLS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last_poll
);
  localparam int CW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  assign last_poll = (cnt_q == LAST_VAL);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (bump && !last_poll) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_VAL);
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import poll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int STAT_BIT = 7,
  parameter int FLAG_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] expect_in,
  input  logic          accept,
  input  logic [DW-1:0] rd_data,
  input  logic          last_poll,
  output logic          go,
  output logic          reading,
  output logic          wd_clear,
  output logic          wd_bump,
  output logic          done,
  output logic          busy,
  output logic [1:0]    result,
  output logic [DW-1:0] data_out
);
  st_e  state_q;
  res_e res_q;
  logic exp_q;
  logic match;
  logic flag;

  assign match    = (rd_data[STAT_BIT] == exp_q);
  assign flag     = rd_data[FLAG_BIT];
  assign go       = (state_q == ST_IDLE) && start;
  assign reading  = (state_q != ST_IDLE);
  assign busy     = reading;
  assign wd_clear = go;
  assign wd_bump  = accept && (state_q == ST_POLL) && !match && !flag;
  assign result   = res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      res_q    <= RES_NONE;
      exp_q    <= 1'b0;
      done     <= 1'b0;
      data_out <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (go) begin
            state_q  <= ST_POLL;
            exp_q    <= expect_in[STAT_BIT];
            done     <= 1'b0;
            res_q    <= RES_NONE;
            data_out <= '0;
          end
        end
        ST_POLL: begin
          if (accept) begin
            if (match) begin
              state_q <= ST_FINAL;
            end else if (flag) begin
              state_q <= ST_RECHK;
            end else if (last_poll) begin
              state_q  <= ST_IDLE;
              done     <= 1'b1;
              res_q    <= RES_TIMEOUT;
              data_out <= rd_data;
            end
          end
        end
        ST_RECHK: begin
          if (accept) begin
            if (match) begin
              state_q <= ST_FINAL;
            end else begin
              state_q  <= ST_IDLE;
              done     <= 1'b1;
              res_q    <= RES_FAIL;
              data_out <= rd_data;
            end
          end
        end
        default: begin
          if (accept) begin
            state_q  <= ST_IDLE;
            done     <= 1'b1;
            res_q    <= RES_PASS;
            data_out <= rd_data;
          end
        end
      endcase
    end
  end

  p_done_busy_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(result) && $stable(data_out)));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(exp_q));

  p_result_code_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != RES_NONE));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW        = 24,
  parameter int DW        = 8,
  parameter int MAX_POLLS = 1024,
  parameter int STAT_BIT  = 7,
  parameter int FLAG_BIT  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] expect_in,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [1:0]    result,
  output logic [DW-1:0] data_out,
  output logic          busy
);
  logic go;
  logic reading;
  logic accept;
  logic wd_clear;
  logic wd_bump;
  logic last_poll;

  poll_fsm #(
    .DW(DW), .STAT_BIT(STAT_BIT), .FLAG_BIT(FLAG_BIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .start(start), .expect_in(expect_in),
    .accept(accept), .rd_data(rd_data), .last_poll(last_poll),
    .go(go), .reading(reading), .wd_clear(wd_clear), .wd_bump(wd_bump),
    .done(done), .busy(busy), .result(result), .data_out(data_out)
  );

  poll_rd_port #(.AW(AW)) u_port (
    .clk(clk), .rst(rst), .go(go), .addr_d(addr_in), .reading(reading),
    .rd_ack(rd_ack), .rd_req(rd_req), .rd_addr(rd_addr), .accept(accept)
  );

  poll_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wd (
    .clk(clk), .rst(rst), .clear(wd_clear), .bump(wd_bump),
    .last_poll(last_poll)
  );

  p_idle_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !go) |=> !rd_req);
endmodule

// File: tb/sim_flash_done_poller.sv
`timescale 1ns/1ps
module sim_flash_done_poller;
  localparam int AW   = 16;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0]    expect_in = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack = 1'b0;
  logic [7:0]    rd_data = '0;
  logic          done;
  logic [1:0]    result;
  logic [7:0]    data_out;
  logic          busy;

  flash_done_poller #(.AW(AW), .DW(8), .MAX_POLLS(MAXP)) u0 (
    .clk(clk), .rst(rst), .start(start), .addr_in(addr_in),
    .expect_in(expect_in), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .done(done), .result(result),
    .data_out(data_out), .busy(busy)
  );

  always #10 clk = ~clk;

  int errs = 0;
  int checks = 0;
  logic [7:0]    scr [16];
  int            ridx = 0;
  int            addr_bad = 0;
  logic [AW-1:0] exp_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Reference walk of the status script, per the requirements.
  function automatic void ref_run(input logic [7:0] e, output logic [1:0] r,
                                  output logic [7:0] d, output int n);
    int i = 0;
    int polls = 0;
    logic [7:0] b;
    r = 2'b00; d = 8'h00;
    while (r == 2'b00 && i < 14) begin
      b = scr[i]; i++;
      if (b[7] == e[7]) begin
        d = scr[i]; i++; r = 2'b01;
      end else if (b[5]) begin
        b = scr[i]; i++;
        if (b[7] == e[7]) begin d = scr[i]; i++; r = 2'b01; end
        else begin d = b; r = 2'b10; end
      end else begin
        polls++;
        if (polls == MAXP) begin d = b; r = 2'b11; end
      end
    end
    n = i;
  endfunction

  // Flash read responder with random latency.
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        repeat ($urandom % 3) @(negedge clk);
        if (rd_addr !== exp_addr) addr_bad++;
        rd_data = (ridx < 16) ? scr[ridx] : 8'h00;
        ridx++;
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
      end
    end
  end

  task automatic run(input logic [AW-1:0] a, input logic [7:0] e,
                     input bit poke, input string tag);
    logic [1:0] er; logic [7:0] ed; int en; int w;
    ref_run(e, er, ed, en);
    @(negedge clk);
    ridx = 0; addr_bad = 0; exp_addr = a;
    start = 1'b1; addr_in = a; expect_in = e;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R9", {tag, " busy after start"},
        {busy, done}, 2'b10);
    if (poke) begin
      repeat (2) @(negedge clk);
      chk(busy === 1'b1, "R7", {tag, " still busy before poke"}, busy, 1);
      start = 1'b1; addr_in = a ^ 1; expect_in = ~e;
      @(negedge clk);
      start = 1'b0;
    end
    w = 0;
    while (done !== 1'b1 && w < 400) begin @(negedge clk); w++; end
    chk(done === 1'b1, "R9", {tag, " done reached"}, done, 1);
    chk(busy === 1'b0, "R9", {tag, " busy low at done"}, busy, 0);
    chk(result === er, "R3", {tag, " result code (R5/R6)"}, result, er);
    chk(data_out === ed, "R3", {tag, " data_out (R5/R6)"}, data_out, ed);
    chk(ridx == en, "R4", {tag, " read count"}, ridx, en);
    chk(addr_bad == 0, "R2", {tag, " read address"}, addr_bad, 0);
    repeat (3) @(negedge clk);
    chk(done === 1'b1 && result === er && data_out === ed && !rd_req, "R8",
        {tag, " outputs held"}, {done, result}, {1'b1, er});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R9 watchdog expired actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 16; i++) scr[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!rd_req && !done && !busy && result == 2'b00 && data_out == 8'h00,
        "R1", "reset outputs", {rd_req, done, busy}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_req && !done && !busy && result == 2'b00, "R1", "after reset",
        {rd_req, done, busy}, 0);

    // R3: immediate match, program data with bit 7 clear
    scr[0] = 8'h00; scr[1] = 8'h5A;
    run(16'h0123, 8'h5A, 0, "R3 direct pass");
    // R4: erase, two mismatches then match
    scr[0] = 8'h00; scr[1] = 8'h4C; scr[2] = 8'h80; scr[3] = 8'hFF;
    run(16'h8000, 8'hFF, 0, "R4 erase poll");
    // R5: recheck passes
    scr[0] = 8'h20; scr[1] = 8'hA0; scr[2] = 8'hFF;
    run(16'h0040, 8'hFF, 0, "R5 recheck pass");
    // R5: recheck fails
    scr[0] = 8'h20; scr[1] = 8'h24;
    run(16'h0041, 8'h80, 0, "R5 recheck fail");
    // R6: timeout after MAXP polls
    for (int i = 0; i < 16; i++) scr[i] = 8'h11;
    run(16'h0777, 8'h80, 0, "R6 timeout");
    // R5: flag on the last allowed poll takes priority over timeout
    for (int i = 0; i < 5; i++) scr[i] = 8'h00;
    scr[5] = 8'h20; scr[6] = 8'h80; scr[7] = 8'h33;
    run(16'h0100, 8'hC3, 0, "R5 flag on last poll");
    // R7: start while busy ignored
    for (int i = 0; i < 16; i++) scr[i] = 8'h11;
    run(16'h0AAA, 8'h80, 1, "R7 start while busy");

    // Random streams
    for (int t = 0; t < 40; t++) begin
      logic [7:0] e;
      e = 8'($urandom);
      for (int i = 0; i < 16; i++) begin
        logic [7:0] b;
        b = 8'($urandom);
        if ($urandom % 4 != 0) b[7] = ~e[7];
        if ($urandom % 4 != 0) b[5] = 1'b0;
        scr[i] = b;
      end
      repeat ($urandom % 4) @(negedge clk);
      run(AW'($urandom), e, 0, "R4 random");
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule